// File: doc/BRIEF.md
# Keypad Event Queue with Consuming and Non-Consuming Reads

This block buffers keypad events between a key-matrix front end and a command decoder. Each event arrives as a one-cycle valid strobe carrying a 7-bit key code and a release flag. It is packed into one byte, with the release flag in bit 7 and the code in bits 6:0. The byte is stored in a 16-slot circular queue. The queue is described by a start pointer and an occupancy count, and the next free slot is (start + count) mod 16.

The decoder reads the queue in two ways. A consuming read first steps the start pointer forward and then returns the slot it now points at. It refuses to run when fewer than two entries are held. A non-consuming read returns the slot at a byte offset from the start pointer and changes nothing. Both results appear one cycle after the request. Each stored event raises the keypad bit of a status byte. An event that finds the queue full sets a sticky overflow error and the error bit of the status byte. A configuration-write strobe empties the queue and clears the status byte.

Top module: `keyq_top`

## Requirements
- R1: After reset the count is 0, the status byte and the error byte are 0x00, and no read result is flagged valid.
- R2: An accepted event writes {release, code} into slot (start + count) mod 16, raises the count by one and sets status bit 0 (keypad event pending).
- R3: A consuming read while the count is 2 or more advances start by one mod 16, lowers the count by one, and returns the slot at the new start on rd_data_o with rd_valid_o high in the following cycle.
- R4: A consuming read while the count is 0 or 1 returns 0x00 and leaves start and count unchanged.
- R5: A non-consuming read at offset i returns slot (start + i) mod 16 when i < count and 0x00 when i >= count. In both cases the count and the start pointer stay unchanged.
- R6: An event that arrives while the count is 16 is discarded, sets error bit 6 (overflow) and sets status bit 3 (error pending). The count stays at 16.
- R7: While status bit 3 and error bit 6 are both set, further events are dropped and nothing else changes.
- R8: A configuration-write strobe sets start and count to 0 and clears the status byte. The error byte keeps its value, and any event or read request in the same cycle is ignored.
- R9: When an event and a consuming read share a cycle, the read is applied first and the event is then stored using the updated start and count.
- R10: Slot indices wrap from 15 to 0 for writes, consuming reads and non-consuming reads.
- R11: When both read kinds are requested in one cycle, only the consuming read takes effect and returns data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | One-cycle strobe: a key event is offered |
| ev_code_i | input | 7 | Key code of the event |
| ev_release_i | input | 1 | 1 for a release event, 0 for a press event |
| cfg_clr_i | input | 1 | Configuration-write strobe, empties the queue |
| pop_i | input | 1 | Consuming read request |
| peek_i | input | 1 | Non-consuming read request |
| peek_idx_i | input | 8 | Byte offset for the non-consuming read |
| rd_valid_o | output | 1 | Read result valid (one cycle after a request) |
| rd_data_o | output | 8 | Read result byte |
| len_o | output | 5 | Current occupancy, 0 to 16 |
| status_o | output | 8 | Status byte: bit 0 keypad pending, bit 3 error pending |
| err_o | output | 8 | Error byte: bit 6 queue overflow |

## Verification
A wrong start pointer shows up on the next read of either kind. It returns a neighbour of the expected byte, one cycle after the request. A count that is off by one shows up at once on len_o. It also shows as a zero where data was due, or data where zero was due, at the boundaries of 0, 1 and 16 entries. The stimulus drives the pointer across slot 15 with a combined push and pop in one cycle, so an ordering or wrap fault reaches the read data within a few operations.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
    localparam int STATUS_KEY_BIT = 0;
    localparam int STATUS_ERR_BIT = 3;
    localparam int ERROR_OVF_BIT  = 6;
endpackage

// File: rtl/keyq_store.sv
module keyq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_b
);
    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (wr_addr == AW'(g)))
                slot_q[g] <= wr_data;
        end
    end

    assign rd_data_a = slot_q[rd_addr_a];
    assign rd_data_b = slot_q[rd_addr_b];
endmodule

// File: rtl/keyq_ctrl.sv
module keyq_ctrl
    import keyq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 7,
    parameter int IDX_W  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int DW    = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              ev_release,
    input  logic              cfg_clr,
    input  logic              pop,
    input  logic              peek,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [AW-1:0]     pop_addr,
    input  logic [DW-1:0]     pop_data,
    output logic [AW-1:0]     peek_addr,
    input  logic [DW-1:0]     peek_data,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic [CW-1:0]     len,
    output logic [7:0]        status,
    output logic [7:0]        err
);
    typedef struct packed {
        logic [AW-1:0] start;
        logic [CW-1:0] len;
        logic [7:0]    status;
        logic [7:0]    err;
        logic          rd_valid;
        logic [DW-1:0] rd_data;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        drop_all;

    assign pop_addr  = st_q.start + AW'(1);
    assign peek_addr = st_q.start + AW'(peek_idx);
    assign wr_data   = {ev_release, ev_code};
    assign drop_all  = st_q.status[STATUS_ERR_BIT] && st_q.err[ERROR_OVF_BIT];

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        wr_en         = 1'b0;
        wr_addr       = '0;
        if (cfg_clr) begin
            st_d.start  = '0;
            st_d.len    = '0;
            st_d.status = '0;
        end else begin
            if (pop) begin
                st_d.rd_valid = 1'b1;
                if (st_q.len <= CW'(1)) begin
                    st_d.rd_data = '0;
                end else begin
                    st_d.start   = pop_addr;
                    st_d.len     = st_q.len - CW'(1);
                    st_d.rd_data = pop_data;
                end
            end else if (peek) begin
                st_d.rd_valid = 1'b1;
                if (int'(peek_idx) >= int'(st_q.len))
                    st_d.rd_data = '0;
                else
                    st_d.rd_data = peek_data;
            end
            if (ev_valid && !drop_all) begin
                if (st_d.len == CW'(DEPTH)) begin
                    st_d.err[ERROR_OVF_BIT]     = 1'b1;
                    st_d.status[STATUS_ERR_BIT] = 1'b1;
                end else begin
                    wr_en   = 1'b1;
                    wr_addr = st_d.start + st_d.len[AW-1:0];
                    st_d.len = st_d.len + CW'(1);
                    st_d.status[STATUS_KEY_BIT] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;
    assign len      = st_q.len;
    assign status   = st_q.status;
    assign err      = st_q.err;
endmodule

// File: rtl/keyq_top.sv
module keyq_top #(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 7,
    parameter int IDX_W  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int DW    = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid_i,
    input  logic [CODE_W-1:0] ev_code_i,
    input  logic              ev_release_i,
    input  logic              cfg_clr_i,
    input  logic              pop_i,
    input  logic              peek_i,
    input  logic [IDX_W-1:0]  peek_idx_i,
    output logic              rd_valid_o,
    output logic [DW-1:0]     rd_data_o,
    output logic [CW-1:0]     len_o,
    output logic [7:0]        status_o,
    output logic [7:0]        err_o
);
    logic          wr_en;
    logic [AW-1:0] wr_addr, pop_addr, peek_addr;
    logic [DW-1:0] wr_data, pop_data, peek_data;

    keyq_ctrl #(.DEPTH(DEPTH), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid_i), .ev_code(ev_code_i), .ev_release(ev_release_i),
        .cfg_clr(cfg_clr_i), .pop(pop_i), .peek(peek_i), .peek_idx(peek_idx_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pop_addr(pop_addr), .pop_data(pop_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .rd_valid(rd_valid_o), .rd_data(rd_data_o),
        .len(len_o), .status(status_o), .err(err_o)
    );

    keyq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(pop_addr), .rd_data_a(pop_data),
        .rd_addr_b(peek_addr), .rd_data_b(peek_data)
    );
endmodule

// File: rtl/keyq_chk.sv
module keyq_chk #(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 7,
    parameter int IDX_W  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int DW    = CODE_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid_i,
    input logic [CODE_W-1:0] ev_code_i,
    input logic              ev_release_i,
    input logic              cfg_clr_i,
    input logic              pop_i,
    input logic              peek_i,
    input logic [IDX_W-1:0]  peek_idx_i,
    input logic              rd_valid_o,
    input logic [DW-1:0]     rd_data_o,
    input logic [CW-1:0]     len_o,
    input logic [7:0]        status_o,
    input logic [7:0]        err_o
);
    logic locked;
    assign locked = status_o[3] && err_o[6];

    // R2
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_o <= CW'(DEPTH));

    // R2
    push_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && !cfg_clr_i && !pop_i && !locked && len_o < CW'(DEPTH))
        |=> (status_o[0] && len_o == $past(len_o) + CW'(1)));

    // R4
    short_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !cfg_clr_i && !ev_valid_i && len_o <= CW'(1))
        |=> (len_o == $past(len_o) && rd_valid_o && rd_data_o == '0));

    // R5
    peek_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_i && !pop_i && !ev_valid_i && !cfg_clr_i) |=> ($stable(len_o) && rd_valid_o));

    // R6
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && !cfg_clr_i && !pop_i && !locked && len_o == CW'(DEPTH))
        |=> (err_o[6] && status_o[3] && len_o == CW'(DEPTH)));

    // R7
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && locked && !cfg_clr_i && !pop_i)
        |=> ($stable(len_o) && $stable(status_o) && $stable(err_o)));

    // R8
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr_i |=> (len_o == '0 && status_o == '0 && !rd_valid_o && err_o == $past(err_o)));

    // R1
    no_spurious_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_i && !peek_i) |=> !rd_valid_o);
endmodule

bind keyq_top keyq_chk #(.DEPTH(DEPTH), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_keyq_chk (.*);

// File: tb/tb_keyq_top.sv
module tb_keyq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid_i = 1'b0, ev_release_i = 1'b0, cfg_clr_i = 1'b0;
    logic       pop_i = 1'b0, peek_i = 1'b0;
    logic [6:0] ev_code_i = '0;
    logic [7:0] peek_idx_i = '0;
    logic       rd_valid_o;
    logic [7:0] rd_data_o, status_o, err_o;
    logic [4:0] len_o;

    always #5 clk = ~clk;

    keyq_top dut (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] mdl [16];
    int ms = 0, ml = 0;
    bit m_key = 0, m_errst = 0, m_ovf = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(bit ev, logic [6:0] code, bit rel, bit pop, bit peek, int idx, bit cfg,
                        string tag);
        ev_valid_i = ev; ev_code_i = code; ev_release_i = rel;
        pop_i = pop; peek_i = peek; peek_idx_i = 8'(idx); cfg_clr_i = cfg;
        if (cfg) begin
            ms = 0; ml = 0; m_key = 0; m_errst = 0;
        end else begin
            if (pop) begin
                if (ml <= 1) exp_q.push_back(8'h00);
                else begin
                    ms = (ms + 1) % 16; ml--;
                    exp_q.push_back(mdl[ms]);
                end
                tag_q.push_back(tag);
            end else if (peek) begin
                exp_q.push_back(idx >= ml ? 8'h00 : mdl[(ms + idx) % 16]);
                tag_q.push_back(tag);
            end
            if (ev && !(m_errst && m_ovf)) begin
                if (ml == 16) begin
                    m_ovf = 1; m_errst = 1;
                end else begin
                    mdl[(ms + ml) % 16] = {rel, code};
                    ml++; m_key = 1;
                end
            end
        end
        @(negedge clk);
        ev_valid_i = 0; pop_i = 0; peek_i = 0; cfg_clr_i = 0;
    endtask

    task automatic check_state(string req);
        chk({req, " len"}, int'(len_o), ml);
        chk({req, " status"}, int'(status_o), (int'(m_errst) << 3) | int'(m_key));
        chk({req, " err"}, int'(err_o), int'(m_ovf) << 6);
    endtask

    // monitor: compares read results with the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: actual %0h expected none", rd_data_o);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data_o !== e) begin
                    n_bad++;
                    $display("FAIL %s read: actual %0h expected %0h", t, rd_data_o, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_valid", int'(rd_valid_o), 0);
        check_state("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: three events
        step(1, 7'h11, 0, 0, 0, 0, 0, "R2");
        step(1, 7'h22, 1, 0, 0, 0, 0, "R2");
        step(1, 7'h33, 0, 0, 0, 0, 0, "R2");
        check_state("R2");
        // R5: peeks inside and past the count
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, i, 0, "R5");
        step(0, 0, 0, 0, 1, 200, 0, "R5");
        check_state("R5");
        // R3: consuming reads
        step(0, 0, 0, 1, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 0, 0, 0, "R3");
        check_state("R3");
        // R4: refused pop at count 1
        step(0, 0, 0, 1, 0, 0, 0, "R4");
        check_state("R4");
        // R8: clear with an event in the same cycle
        step(1, 7'h05, 0, 0, 0, 0, 1, "R8");
        check_state("R8");
        // R6: fill then overflow
        for (int i = 0; i < 16; i++) step(1, 7'(8'h40 + i), i[0], 0, 0, 0, 0, "R6");
        check_state("R6 full");
        step(1, 7'h7E, 0, 0, 0, 0, 0, "R6");
        check_state("R6");
        // R7: further events dropped while locked
        step(1, 7'h01, 1, 0, 0, 0, 0, "R7");
        step(1, 7'h02, 0, 0, 0, 0, 0, "R7");
        check_state("R7");
        step(0, 0, 0, 0, 1, 15, 0, "R7");
        // R8: clear empties, error byte kept
        step(0, 0, 0, 0, 0, 0, 1, "R8");
        check_state("R8 clear");
        // R9 and R10: fill, then push+pop at full, wrap writes to slot 0
        for (int i = 0; i < 16; i++) step(1, 7'(8'h50 + i), 0, 0, 0, 0, 0, "R9");
        step(1, 7'h7F, 0, 1, 0, 0, 0, "R9");
        check_state("R9");
        step(0, 0, 0, 0, 1, 15, 0, "R10");
        for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 0, 0, 0, "R10");
        check_state("R10");
        // R11: pop and peek together
        step(1, 7'h2A, 1, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 1, 1, 0, 0, "R11");
        check_state("R11");
        step(0, 0, 0, 0, 0, 0, 0, "idle");
        chk("R3 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule